// File: doc/BRIEF.md
# Auxiliary Snapshot Capture Unit

This unit records the system time whenever an asynchronous trigger pin rises. The time arrives on an input bus as a seconds word and a sub-second word. Each captured pair goes into a small first-in, first-out store. Software learns how many pairs are waiting from a live count field, and it is alerted by a timestamp interrupt flag. A pulse on the status-read strobe models a read of the status register. That read clears the interrupt, the sticky overflow bit and the pulse-per-second flag. The pulse-per-second event is a second source of the same interrupt.

Snapshots leave through a valid/ready word stream. Each stored entry is sent as two beats: first the sub-second word with `snap_last` low, then the seconds word with `snap_last` high. A beat transfers on a clock edge where `snap_valid` and `snap_ready` are both high. While `snap_ready` is low the unit holds the current beat unchanged. The entry is released, and the count drops, only when the seconds beat transfers.

Top module: `snap_capture_unit`

## Requirements
- R1: The trigger passes through a two-stage synchronizer, and only its rising edge captures. A trigger held high for many cycles yields exactly one capture. The count shows the capture within three clock edges of the trigger rising.
- R2: A capture stores the values of `tm_sec` and `tm_subsec` present at the capture edge.
- R3: Each entry is streamed as the sub-second word (`snap_last`=0), then the seconds word (`snap_last`=1). While `snap_valid` is high and `snap_ready` is low, `snap_word` and `snap_last` stay stable.
- R4: Entries leave oldest first. The seconds-beat handshake releases the entry and lowers `stat_count` by one.
- R5: The store holds DEPTH entries (default 4). `stat_count` gives the number held, from 0 to DEPTH, and `snap_valid` is high exactly when it is nonzero.
- R6: A capture while the store is full is dropped. The count and the stored entries are unchanged, and `stat_ovf` is set and stays set until a status read.
- R7: `ts_irq` is set by a successful capture or by a `pps_evt` pulse, and it stays set until a status read. `pps_evt` also sets `stat_pps`.
- R8: A `stat_rd` pulse clears `ts_irq`, `stat_ovf` and `stat_pps` on the next edge. A setting event in the same cycle as the read wins, and the flag stays set.
- R9: While `cap_en` is low, trigger edges are ignored. Stored entries are kept and can still be streamed out.
- R10: After reset, `stat_count` is 0, `snap_valid` is 0, and `ts_irq`, `stat_ovf` and `stat_pps` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous capture trigger |
| cap_en | input | 1 | Capture enable |
| tm_sec | input | SEC_W | Current seconds |
| tm_subsec | input | SUB_W | Current sub-second value |
| pps_evt | input | 1 | Pulse-per-second start/end event, one cycle |
| stat_rd | input | 1 | Status read strobe, one cycle |
| stat_count | output | CNT_W | Number of snapshots held |
| stat_ovf | output | 1 | Sticky dropped-capture flag |
| stat_pps | output | 1 | Pulse-per-second event flag |
| ts_irq | output | 1 | Timestamp interrupt |
| snap_valid | output | 1 | Stream beat available |
| snap_ready | input | 1 | Stream consumer ready |
| snap_word | output | WORD_W | Stream beat data |
| snap_last | output | 1 | High on the seconds beat |

## Verification
A pointer or count that drifts shows up at the ports in one of two ways. A snapshot word may come out of the stream in the wrong order or with the wrong value. Or `stat_count` may disagree with the number of triggers that were accepted. The stream scoreboard catches either case on the next handshake after the fault. A read-phase error shows up as `snap_last` out of step on the very next beat. A flag that misses its set or clear is visible on the cycle after the event or after `stat_rd`.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic {PH_SUB = 1'b0, PH_SEC = 1'b1} rd_phase_e;
endpackage

// File: rtl/snap_sync.sv
module snap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign rise = chain[STAGES-1] & ~prev;

  // R1: a held level yields a single-cycle pulse
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/snap_fifo.sv
module snap_fifo
  import snap_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 32,
  parameter int WORD_W = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [SEC_W-1:0]  push_sec,
  input  logic [SUB_W-1:0]  push_sub,
  output logic              push_ok,
  output logic [CNT_W-1:0]  count,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_word,
  output logic              out_last
);
  logic [SEC_W-1:0] sec_mem [DEPTH];
  logic [SUB_W-1:0] sub_mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  rd_phase_e        phase;
  logic             hs, pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign push_ok   = push && (count != CNT_W'(DEPTH));
  assign out_valid = (count != '0);
  assign hs        = out_valid && out_ready;
  assign pop       = hs && (phase == PH_SEC);
  assign out_last  = (phase == PH_SEC);
  assign out_word  = (phase == PH_SEC) ? WORD_W'(sec_mem[rd_ptr])
                                       : WORD_W'(sub_mem[rd_ptr]);

  always_ff @(posedge clk) begin
    if (push_ok) begin
      sec_mem[wr_ptr] <= push_sec;
      sub_mem[wr_ptr] <= push_sub;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      phase  <= PH_SUB;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop)     rd_ptr <= bump(rd_ptr);
      if (hs)      phase  <= (phase == PH_SUB) ? PH_SEC : PH_SUB;
      case ({push_ok, pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  // R5: occupancy never exceeds the depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R3: a stalled beat stays put
  a_r3_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_last)));
  // R4: a release without a push lowers the count by one
  a_r4_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - CNT_W'(1)));
  // R6: a push into a full store without a release leaves the count alone
  a_r6_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count == CNT_W'(DEPTH) && !hs) |=> (count == CNT_W'(DEPTH)));
endmodule

// File: rtl/snap_status.sv
module snap_status (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_done,
  input  logic cap_drop,
  input  logic pps_evt,
  input  logic stat_rd,
  output logic ts_irq,
  output logic stat_ovf,
  output logic stat_pps
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_irq   <= 1'b0;
      stat_ovf <= 1'b0;
      stat_pps <= 1'b0;
    end else begin
      ts_irq   <= cap_done | pps_evt | (ts_irq & ~stat_rd);
      stat_ovf <= cap_drop | (stat_ovf & ~stat_rd);
      stat_pps <= pps_evt | (stat_pps & ~stat_rd);
    end
  end

  // R7: a capture raises the interrupt
  a_r7_capture_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done |=> ts_irq);
  // R8: a read with no new event clears every flag
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !cap_done && !cap_drop && !pps_evt) |=> (!ts_irq && !stat_ovf && !stat_pps));
  // R6: overflow stays until read
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ovf && !stat_rd) |=> stat_ovf);
endmodule

// File: rtl/snap_capture_unit.sv
module snap_capture_unit #(
  parameter int DEPTH  = 4,
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 32,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W = (SEC_W > SUB_W) ? SEC_W : SUB_W,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_in,
  input  logic              cap_en,
  input  logic [SEC_W-1:0]  tm_sec,
  input  logic [SUB_W-1:0]  tm_subsec,
  input  logic              pps_evt,
  input  logic              stat_rd,
  output logic [CNT_W-1:0]  stat_count,
  output logic              stat_ovf,
  output logic              stat_pps,
  output logic              ts_irq,
  output logic              snap_valid,
  input  logic              snap_ready,
  output logic [WORD_W-1:0] snap_word,
  output logic              snap_last
);
  logic trig_rise, capture, cap_ok;

  snap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(trig_in), .rise(trig_rise));

  assign capture = trig_rise & cap_en;

  snap_fifo #(.DEPTH(DEPTH), .SEC_W(SEC_W), .SUB_W(SUB_W), .WORD_W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(capture), .push_sec(tm_sec), .push_sub(tm_subsec),
    .push_ok(cap_ok), .count(stat_count), .out_valid(snap_valid), .out_ready(snap_ready),
    .out_word(snap_word), .out_last(snap_last));

  snap_status u_stat (
    .clk(clk), .rst_n(rst_n), .cap_done(cap_ok), .cap_drop(capture & ~cap_ok),
    .pps_evt(pps_evt), .stat_rd(stat_rd), .ts_irq(ts_irq), .stat_ovf(stat_ovf),
    .stat_pps(stat_pps));

  // R9: with capture disabled the count cannot rise
  a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> (stat_count <= $past(stat_count)));
endmodule

// File: tb/sim_snap_capture_unit.sv
module sim_snap_capture_unit;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trig_in = 0, cap_en = 0, pps_evt = 0, stat_rd = 0, snap_ready = 0;
  logic [31:0] tm_sec = 0, tm_subsec = 0;
  logic [2:0]  stat_count;
  logic stat_ovf, stat_pps, ts_irq, snap_valid, snap_last;
  logic [31:0] snap_word;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit drain = 0, exp_last = 0, stalled = 0, prev_last = 0;
  logic [31:0] prev_word = 0;
  logic [63:0] q[$];

  always #10 clk = ~clk;

  snap_capture_unit u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire(logic [31:0] s, logic [31:0] ss);
    @(negedge clk);
    tm_sec = s; tm_subsec = ss; trig_in = 1;
    if (cap_en && q.size() < 4) q.push_back({s, ss});
    repeat (8) @(negedge clk);
    trig_in = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic read_status();
    @(negedge clk); stat_rd = 1;
    @(negedge clk); stat_rd = 0;
  endtask

  // monitor: drives ready, compares every beat
  always @(negedge clk) begin
    cyc++;
    if (stalled && snap_valid) begin
      chk("R3 stalled word", snap_word, prev_word);
      chk("R3 stalled last", 32'(snap_last), 32'(prev_last));
    end
    snap_ready = drain && (cyc % 3 != 1);
    stalled = snap_valid && !snap_ready;
    prev_word = snap_word; prev_last = snap_last;
    if (snap_valid && snap_ready) begin
      if (q.size() == 0) chk("R4 unexpected beat", 32'(snap_valid), 32'd0);
      else begin
        chk("R3 beat order", 32'(snap_last), 32'(exp_last));
        if (!exp_last) chk("R2 subsec word", snap_word, q[0][31:0]);
        else begin
          chk("R2 R4 seconds word", snap_word, q[0][63:32]);
          void'(q.pop_front());
        end
        exp_last = !exp_last;
      end
    end
  end

  task automatic drain_all();
    drain = 1;
    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    drain = 0;
    @(negedge clk);
    chk("R4 drained count", 32'(stat_count), 0);
    chk("R5 valid low when empty", 32'(snap_valid), 0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 count", 32'(stat_count), 0);
    chk("R10 valid", 32'(snap_valid), 0);
    chk("R10 irq", 32'(ts_irq), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 ovf", 32'(stat_ovf), 0);
    chk("R10 pps", 32'(stat_pps), 0);
    cap_en = 1;
    // R1: long high level gives one capture
    fire(32'h10, 32'h1111);
    chk("R1 single capture", 32'(stat_count), 1);
    chk("R7 irq after capture", 32'(ts_irq), 1);
    read_status();
    chk("R8 irq cleared", 32'(ts_irq), 0);
    fire(32'h20, 32'h2222);
    fire(32'h30, 32'h3333);
    fire(32'h40, 32'h4444);
    chk("R5 full count", 32'(stat_count), 4);
    read_status();
    // R6: fifth capture dropped
    fire(32'h50, 32'h5555);
    chk("R6 count held", 32'(stat_count), 4);
    chk("R6 ovf set", 32'(stat_ovf), 1);
    chk("R7 no irq on drop", 32'(ts_irq), 0);
    repeat (3) @(negedge clk);
    chk("R6 ovf sticky", 32'(stat_ovf), 1);
    read_status();
    chk("R8 ovf cleared", 32'(stat_ovf), 0);
    // R9: disabled captures ignored, contents kept
    cap_en = 0;
    fire(32'h60, 32'h6666);
    chk("R9 count kept", 32'(stat_count), 4);
    chk("R9 no irq", 32'(ts_irq), 0);
    drain_all();
    // R7/R8: pps event and read in the same cycle
    cap_en = 1;
    @(negedge clk); pps_evt = 1; stat_rd = 1;
    @(negedge clk); pps_evt = 0; stat_rd = 0;
    chk("R8 set wins pps", 32'(stat_pps), 1);
    chk("R7 pps irq", 32'(ts_irq), 1);
    read_status();
    chk("R8 pps cleared", 32'(stat_pps), 0);
    chk("R8 irq cleared pps", 32'(ts_irq), 0);
    // R4: capture while the stream drains
    drain = 1;
    fire(32'hA0, 32'hAAAA);
    fire(32'hB0, 32'hBBBB);
    fire(32'hC0, 32'hCCCC);
    drain_all();
    finish_run();
  end
endmodule